// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the slave side of a three-wire serial EEPROM: a chip select, a serial clock, a serial data input and a serial data output. It holds a 4-Kbit register array. An organisation input picks 16-bit words or 8-bit bytes, and the width of the address field follows that choice. A host selects the device and clocks in a start bit, a two-bit opcode and an address. Writes also carry data. The block then reads, writes, erases or fills the array, or changes its write-enable latch.

All pins are sampled on the block clock. An instruction advances on each rising edge of the serial clock seen while chip select is high, so the serial clock can run at several MHz with no added delay.

A programming instruction (write, erase, erase-all, write-all) takes effect only when chip select falls after the whole instruction has arrived. After that the block counts a parameterised number of cycles. While the host has the device selected again, the data output reports busy (low) during that count and ready (high) after it.

FSM states:
- `ST_IDLE`: wait for a start bit.
- `ST_OPC`: gather the opcode.
- `ST_ADDR`: gather the address.
- `ST_WDATA`: gather the write data.
- `ST_RDATA`: shift out read data.
- `ST_WAIT`: instruction finished, nothing to do until deselect.
- `ST_ARMED`: programming pending until deselect.
- `ST_PROG`: busy count.
- `ST_READY`: programming done, status high.

Transitions:
- start: `ST_IDLE`/`ST_READY` to `ST_OPC`.
- opcode done: `ST_OPC` to `ST_ADDR`.
- address done: `ST_ADDR` to `ST_RDATA`, `ST_WDATA`, `ST_ARMED` or `ST_WAIT`.
- data done: `ST_WDATA` to `ST_ARMED` or `ST_WAIT`.
- deselect-commit: `ST_ARMED` to `ST_PROG`.
- count done: `ST_PROG` to `ST_READY`.
- abort: any other state to `ST_IDLE` when chip select is low.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the write-enable latch is clear, every array bit reads 1, and `do_en` is 0.
- R2: Zeros clocked in before the first 1 are ignored. The first 1 sampled on a rising `sk` with `cs` high is the start bit. The opcode (2 bits), the address and the data follow it, each MSB first.
- R3: With `org`=1 the address is 8 bits and data is 16 bits. With `org`=0 the address is 9 bits and data is 8 bits. An even byte address maps to bits [15:8] of the 16-bit word selected by address bits [8:1], and an odd byte address maps to bits [7:0].
- R4: Opcode 10 is read. On the rising edge that takes in the last address bit, `do_val` goes to 0 (dummy bit). Each later rising edge presents the next data bit, MSB first. After each word or byte the address steps up by one and wraps from the top of the array to 0, for as long as `cs` stays high.
- R5: Opcode 01 is write. With the latch set, the data is stored when `cs` falls after the last data bit.
- R6: Opcode 11 is erase. With the latch set, the addressed location becomes all ones when `cs` falls.
- R7: With opcode 00, the two top address bits choose the operation. Value 10 is erase-all: every array bit becomes 1. Value 01 is write-all: the data that follows goes to every location.
- R8: With opcode 00, top address bits 11 set the write-enable latch and 00 clear it. While the latch is clear, write, erase, erase-all and write-all change nothing and start no busy period.
- R9: If `cs` falls before an instruction is complete, nothing is executed and no busy period starts.
- R10: After a programming instruction, whenever `cs` is high, `do_val` is 0 for PROG_CYCLES clock cycles from the deselect and 1 after that. `do_en` is 0 whenever `cs` has been low for two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| org | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_val | output | 1 | Serial data out value |
| do_en | output | 1 | Output enable for the data-out pad (0 = high-impedance) |

## Verification
On every cycle the assertions check these rules:
- the output is released while deselected;
- the array is written only with the latch set, and only at a deselect;
- each instruction causes at most one array write;
- the busy state is entered only from a pending commit, and left only when its count is spent.

Only the directed scenarios can show that data values survive the round trip. The same holds for the byte lane mapping in 8-bit mode, sequential reads crossing the wrap point, leading zeros being skipped, and truncated or disabled instructions leaving the array untouched.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT,
        ST_ARMED,
        ST_PROG,
        ST_READY
    } mw_state_e;

    typedef enum logic [2:0] {
        OP_READ,
        OP_WRITE,
        OP_ERASE,
        OP_ERAL,
        OP_WRAL,
        OP_EWEN,
        OP_EWDS
    } mw_op_e;

    // opcode plus the two leading address bits give the operation
    function automatic mw_op_e mw_decode(input logic [1:0] opc, input logic [1:0] ext);
        mw_op_e r;
        unique case (opc)
            2'b10: r = OP_READ;
            2'b01: r = OP_WRITE;
            2'b11: r = OP_ERASE;
            default: begin
                unique case (ext)
                    2'b11:   r = OP_EWEN;
                    2'b10:   r = OP_ERAL;
                    2'b01:   r = OP_WRAL;
                    default: r = OP_EWDS;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    input  logic cs,
    output logic sk_rise,
    output logic cs_s
);
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_s <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_s <= cs;
        end
    end

    assign sk_rise = cs & sk & ~sk_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int NWORDS = 256,
    parameter int AW16   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_all,
    input  logic [AW16-1:0] wr_idx,
    input  logic [15:0]     wr_mask,
    input  logic [15:0]     wr_data,
    input  logic [AW16-1:0] rd_idx,
    output logic [15:0]     rd_word
);
    logic [15:0] cells [NWORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) cells[i] <= '1;
        end else if (wr_en) begin
            for (int i = 0; i < NWORDS; i++) begin
                if (wr_all || (wr_idx == AW16'(i)))
                    cells[i] <= (cells[i] & ~wr_mask) | (wr_data & wr_mask);
            end
        end
    end

    assign rd_word = cells[rd_idx];
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
    parameter int MEM_BITS    = 4096,
    parameter int PROG_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_val,
    output logic do_en
);
    import mw_pkg::*;

    localparam int NWORDS = MEM_BITS / 16;
    localparam int AW16   = $clog2(NWORDS);
    localparam int AW8    = AW16 + 1;
    localparam int CW     = $clog2(PROG_CYCLES + 1);

    mw_state_e        state_q, state_d;
    mw_op_e           op_q, cur_op;
    logic             sk_rise, cs_s;
    logic [4:0]       bitcnt_q;
    logic [1:0]       opc_q;
    logic [AW8-1:0]   addr_q, full_addr, amask;
    logic [15:0]      wdata_q, rd_shift_q, rd_word, rd_aligned;
    logic             do_bit_q, wel_q;
    logic [CW-1:0]    cnt_q;
    logic [4:0]       addr_len, data_len;
    logic [1:0]       ext;
    logic             addr_last, data_last;
    logic [AW16-1:0]  word_idx;
    logic             wr_en, wr_all;
    logic [15:0]      wr_mask, wr_data;

    mw_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .cs      (cs),
        .sk_rise (sk_rise),
        .cs_s    (cs_s)
    );

    // organisation-dependent field lengths and address decode
    assign addr_len  = org ? 5'(AW16) : 5'(AW8);
    assign data_len  = org ? 5'd16 : 5'd8;
    assign full_addr = {addr_q[AW8-2:0], di};
    assign ext       = org ? full_addr[AW16-1 -: 2] : full_addr[AW8-1 -: 2];
    assign cur_op    = mw_decode(opc_q, ext);
    assign addr_last = sk_rise && (bitcnt_q == addr_len - 5'd1);
    assign data_last = sk_rise && (bitcnt_q == data_len - 5'd1);
    assign word_idx  = org ? addr_q[AW16-1:0] : addr_q[AW8-1:1];
    assign amask     = org ? {1'b0, {AW16{1'b1}}} : {AW8{1'b1}};
    assign rd_aligned = org ? rd_word
                            : {(addr_q[0] ? rd_word[7:0] : rd_word[15:8]), 8'h00};

    // commit path: fires on the deselect that leaves ST_ARMED
    assign wr_en   = (state_q == ST_ARMED) && !cs;
    assign wr_all  = (op_q == OP_ERAL) || (op_q == OP_WRAL);
    assign wr_data = ((op_q == OP_ERASE) || (op_q == OP_ERAL)) ? 16'hFFFF
                   : (org ? wdata_q : {wdata_q[7:0], wdata_q[7:0]});
    assign wr_mask = (wr_all || org) ? 16'hFFFF
                   : (addr_q[0] ? 16'h00FF : 16'hFF00);

    mw_array #(.NWORDS(NWORDS), .AW16(AW16)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_idx  (word_idx),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_idx  (word_idx),
        .rd_word (rd_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cs) begin
            unique case (state_q)
                ST_ARMED: state_d = ST_PROG;
                ST_PROG:  state_d = (cnt_q == '0) ? ST_READY : ST_PROG;
                ST_READY: state_d = ST_READY;
                default:  state_d = ST_IDLE;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE, ST_READY: if (sk_rise && di) state_d = ST_OPC;
                ST_OPC:   if (sk_rise && bitcnt_q == 5'd1) state_d = ST_ADDR;
                ST_ADDR: begin
                    if (addr_last) begin
                        unique case (cur_op)
                            OP_READ:            state_d = ST_RDATA;
                            OP_WRITE, OP_WRAL:  state_d = ST_WDATA;
                            OP_ERASE, OP_ERAL:  state_d = wel_q ? ST_ARMED : ST_WAIT;
                            default:            state_d = ST_WAIT;
                        endcase
                    end
                end
                ST_WDATA: if (data_last) state_d = wel_q ? ST_ARMED : ST_WAIT;
                ST_PROG:  if (cnt_q == '0) state_d = ST_READY;
                default:  state_d = state_q;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            opc_q      <= '0;
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_shift_q <= '0;
            do_bit_q   <= 1'b0;
            wel_q      <= 1'b0;
            op_q       <= OP_EWDS;
            cnt_q      <= '0;
        end else begin
            if (state_q == ST_ARMED && !cs)
                cnt_q <= CW'(PROG_CYCLES - 1);
            else if (state_q == ST_PROG && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;

            if (cs && sk_rise) begin
                unique case (state_q)
                    ST_IDLE, ST_READY: begin
                        if (di) begin
                            bitcnt_q <= '0;
                            opc_q    <= '0;
                            addr_q   <= '0;
                            wdata_q  <= '0;
                        end
                    end
                    ST_OPC: begin
                        opc_q    <= {opc_q[0], di};
                        bitcnt_q <= (bitcnt_q == 5'd1) ? 5'd0 : bitcnt_q + 5'd1;
                    end
                    ST_ADDR: begin
                        addr_q <= full_addr;
                        if (addr_last) begin
                            bitcnt_q <= '0;
                            op_q     <= cur_op;
                            if (cur_op == OP_EWEN) wel_q <= 1'b1;
                            if (cur_op == OP_EWDS) wel_q <= 1'b0;
                            if (cur_op == OP_READ) do_bit_q <= 1'b0;
                        end else begin
                            bitcnt_q <= bitcnt_q + 5'd1;
                        end
                    end
                    ST_WDATA: begin
                        wdata_q  <= {wdata_q[14:0], di};
                        bitcnt_q <= bitcnt_q + 5'd1;
                    end
                    ST_RDATA: begin
                        if (bitcnt_q == '0) begin
                            do_bit_q   <= rd_aligned[15];
                            rd_shift_q <= {rd_aligned[14:0], 1'b0};
                        end else begin
                            do_bit_q   <= rd_shift_q[15];
                            rd_shift_q <= {rd_shift_q[14:0], 1'b0};
                        end
                        if (bitcnt_q == data_len - 5'd1) begin
                            bitcnt_q <= '0;
                            addr_q   <= (addr_q + 1'b1) & amask;
                        end else begin
                            bitcnt_q <= bitcnt_q + 5'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        do_en  = 1'b0;
        do_val = 1'b0;
        unique case (state_q)
            ST_RDATA: begin do_en = cs_s; do_val = do_bit_q; end
            ST_PROG:  begin do_en = cs_s; do_val = 1'b0;     end
            ST_READY: begin do_en = cs_s; do_val = 1'b1;     end
            default:  ;
        endcase
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int CW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              do_en,
    input logic              wr_en,
    input logic              wel_q,
    input mw_pkg::mw_state_e state_q,
    input logic [CW-1:0]     cnt_q
);
    import mw_pkg::*;

    AST_DO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && $past(!cs)) |-> !do_en); // R10

    AST_WRITE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wel_q); // R8

    AST_COMMIT_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !cs); // R9

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R5

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && $past(state_q) != ST_PROG) |-> $past(state_q == ST_ARMED)); // R10

    AST_READY_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && $past(state_q) == ST_PROG) |-> $past(cnt_q == '0)); // R10

endmodule

bind mw_eeprom_slave mw_eeprom_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .do_en   (do_en),
    .wr_en   (wr_en),
    .wel_q   (wel_q),
    .state_q (state_q),
    .cnt_q   (cnt_q)
);

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb;
    localparam int PROG = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_val, do_en;
    logic last_do;
    int   n_chk = 0, n_bad = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    mw_eeprom_slave #(.MEM_BITS(4096), .PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .org(org), .cs(cs), .sk(sk), .di(di),
        .do_val(do_val), .do_en(do_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int aw(input logic o); return o ? 8 : 9; endfunction
    function automatic int dw(input logic o); return o ? 16 : 8; endfunction

    task automatic bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            di = v[i];
            sk = 1'b0;
            repeat (4) @(negedge clk);
            sk = 1'b1;
            repeat (4) @(negedge clk);
            last_do = do_val;
            sk = 1'b0;
        end
    endtask

    task automatic sel();
        cs = 1'b0; di = 1'b0;
        repeat (3) @(negedge clk);
        cs = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic desel();
        cs = 1'b0; di = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // read nw units from addr and compare
    task automatic rd_check(input string req, input logic o, input int addr, input int nw,
                            input logic [15:0] e0, input logic [15:0] e1);
        logic [15:0] v;
        org = o;
        sel();
        bits(1, 1);
        bits(2'b10, 2);
        bits(addr, aw(o));
        chk({req, " dummy"}, last_do, 0);
        for (int w = 0; w < nw; w++) begin
            v = '0;
            for (int b = 0; b < dw(o); b++) begin
                bits(0, 1);
                v = {v[14:0], last_do};
            end
            chk(req, v, (w == 0) ? e0 : e1);
        end
        desel();
    endtask

    // programming instruction followed by a status check
    task automatic prog_cmd(input string req, input logic o, input logic [1:0] opc, input int addr,
                            input logic [15:0] dat, input bit has_data, input bit expect_busy,
                            input int lead);
        org = o;
        sel();
        if (lead > 0) bits(0, lead);
        bits(1, 1);
        bits(opc, 2);
        bits(addr, aw(o));
        if (has_data) bits(dat, dw(o));
        desel();
        cs = 1'b1;
        repeat (3) @(negedge clk);
        if (expect_busy) begin
            chk({req, " busy"}, {do_en, do_val}, 2'b10);
            repeat (PROG - 12) @(negedge clk);
            chk({req, " still busy"}, {do_en, do_val}, 2'b10);
            repeat (12) @(negedge clk);
            chk({req, " ready"}, {do_en, do_val}, 2'b11);
        end else begin
            chk({req, " no status"}, do_en, 0);
        end
        desel();
    endtask

    task automatic ctl(input logic [7:0] addr);
        org = 1'b1;
        sel();
        bits(1, 1);
        bits(2'b00, 2);
        bits(addr, 8);
        desel();
    endtask

    task automatic t_reset();
        chk("R1 do_en after reset", do_en, 0);
        rd_check("R1 erased array", 1'b1, 5, 1, 16'hFFFF, 16'h0);
    endtask

    task automatic t_disabled_write();
        prog_cmd("R8 write with latch clear", 1'b1, 2'b01, 3, 16'h1234, 1, 0, 0);
        rd_check("R8 location unchanged", 1'b1, 3, 1, 16'hFFFF, 16'h0);
    endtask

    task automatic t_write();
        ctl(8'hC0);
        prog_cmd("R5 R10 write word", 1'b1, 2'b01, 3, 16'hA5C3, 1, 1, 0);
        rd_check("R5 readback", 1'b1, 3, 1, 16'hA5C3, 16'h0);
        chk("R10 released after deselect", do_en, 0);
    endtask

    task automatic t_leading_zeros();
        prog_cmd("R2 write after zeros", 1'b1, 2'b01, 4, 16'h0F0F, 1, 1, 3);
        rd_check("R2 readback", 1'b1, 4, 1, 16'h0F0F, 16'h0);
    endtask

    task automatic t_seq_wrap();
        prog_cmd("R4 write top", 1'b1, 2'b01, 255, 16'h1111, 1, 1, 0);
        prog_cmd("R4 write zero", 1'b1, 2'b01, 0, 16'h2222, 1, 1, 0);
        rd_check("R4 sequential wrap", 1'b1, 255, 2, 16'h1111, 16'h2222);
    endtask

    task automatic t_erase();
        prog_cmd("R6 erase", 1'b1, 2'b11, 3, 16'h0, 0, 1, 0);
        rd_check("R6 erased word", 1'b1, 3, 1, 16'hFFFF, 16'h0);
    endtask

    task automatic t_abort();
        org = 1'b1;
        sel();
        bits(1, 1);
        bits(2'b01, 2);
        bits(4, 8);
        bits(10'h155, 10);
        desel();
        cs = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 no busy after abort", do_en, 0);
        desel();
        rd_check("R9 word kept", 1'b1, 4, 1, 16'h0F0F, 16'h0);
    endtask

    task automatic t_bytes();
        prog_cmd("R3 byte write", 1'b0, 2'b01, 9, 16'h003C, 1, 1, 0);
        rd_check("R3 even byte", 1'b0, 8, 2, 16'h000F, 16'h003C);
        rd_check("R3 word view", 1'b1, 4, 1, 16'h0F3C, 16'h0);
    endtask

    task automatic t_all();
        prog_cmd("R7 write all", 1'b1, 2'b00, 8'h40, 16'h5A5A, 1, 1, 0);
        rd_check("R7 filled", 1'b1, 100, 2, 16'h5A5A, 16'h5A5A);
        prog_cmd("R7 erase all", 1'b1, 2'b00, 8'h80, 16'h0, 0, 1, 0);
        rd_check("R7 cleared", 1'b1, 100, 1, 16'hFFFF, 16'h0);
    endtask

    task automatic t_disable();
        ctl(8'h00);
        prog_cmd("R8 write after disable", 1'b1, 2'b01, 7, 16'h0000, 1, 0, 0);
        rd_check("R8 word unchanged", 1'b1, 7, 1, 16'hFFFF, 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_disabled_write();
        t_write();
        t_leading_zeros();
        t_seq_wrap();
        t_erase();
        t_abort();
        t_bytes();
        t_all();
        t_disable();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule